// File: doc/BRIEF.md
# Histogram Channel Increment Engine

This block sits behind the stage that turns tagged event words into histogram channel addresses. Each address it is offered is a location in external memory holding a 32-bit bin count. Addresses arrive in short fast bursts, so they are taken into a small first-in first-out buffer. A sequencer empties that buffer at the slower rate that external memory allows. For every buffered address it fetches the bin, adds one and stores the result back at the same place.

The buffer never pushes back on the address source. If an address comes in while every slot is taken, the address is thrown away. A saturating loss counter then counts up, and a sticky overflow line is raised that can serve as an interrupt. A host clears both with one pulse. A collection enable gates the whole block. A test mode stops the sequencer from taking entries, so the host can look at the oldest buffered address and remove entries one by one.

Memory is reached through a simple request/acknowledge master port. A request lasts one cycle. The acknowledge may come any number of cycles later, and a read acknowledge carries the data.

Top module: `hist_incr_engine`

## Requirements
- R1: With `enable` high, an `in_valid` cycle stores `in_addr` into the buffer when fewer than DEPTH (default 16) entries are held. Entries are processed in arrival order.
- R2: For each entry, the engine first issues a one-cycle read request (`mem_req`=1, `mem_we`=0) to the entry's address. After the read acknowledge it issues a one-cycle write request (`mem_req`=1, `mem_we`=1) to the same address, carrying the data that was read plus one.
- R3: The increment is modulo 2^32: a bin holding 0xFFFFFFFF is written back as 0x00000000.
- R4: An entry leaves the buffer only when its write is acknowledged, so one increment finishes before the next begins. Repeated addresses therefore accumulate one count each.
- R5: With `enable` high, an `in_valid` cycle that finds the buffer full discards the address and adds one to `lost_count`.
- R6: `lost_count` stops at its all-ones value and does not wrap.
- R7: `overflow` becomes 1 in the cycle after a discard and stays 1 until a `lost_clr` pulse. `lost_clr` sets both `lost_count` and `overflow` to zero.
- R8: While `enable` is low, `in_valid` is ignored: nothing is stored and nothing is counted. No new increment starts, but an increment that has already begun completes its write.
- R9: While `test_mode` is high and the engine is idle, no memory request is issued. `fifo_head` shows the oldest entry, a `host_pop` cycle removes it, and `fifo_empty` reports an empty buffer.
- R10: After reset, `mem_req`, `lost_count` and `overflow` are 0 and `fifo_empty` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Collection enable |
| test_mode | input | 1 | Host takes buffer entries instead of the engine |
| in_valid | input | 1 | Channel address offered this cycle |
| in_addr | input | ADDR_W | Channel address |
| host_pop | input | 1 | Remove oldest entry (test mode, engine idle) |
| fifo_head | output | ADDR_W | Oldest buffered address |
| fifo_empty | output | 1 | Buffer holds no entry |
| lost_clr | input | 1 | Clear loss counter and overflow flag |
| lost_count | output | LOST_W | Saturating count of discarded addresses |
| overflow | output | 1 | Sticky discard indication |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | ADDR_W | Memory address |
| mem_wdata | output | DATA_W | Write data |
| mem_ack | input | 1 | Memory acknowledge |
| mem_rdata | input | DATA_W | Read data, valid with a read acknowledge |

## Verification
The assertions rely on the memory side behaving well. There must be exactly one `mem_ack` per request, arriving at least one cycle after it, and `mem_rdata` must be valid in the acknowledge cycle of a read. The bench's memory responder only acknowledges requests it has recorded, with a latency of one to four cycles that changes from request to request. It never holds more than one request outstanding. Mode changes are driven on the falling edge. The bench switches into test mode only after it has seen the engine drain every expected write, so a host pop never competes with a running increment.

// File: rtl/hist_incr_engine.sv
module hist_incr_engine #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 16,
  parameter int LOST_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              test_mode,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic              host_pop,
  output logic [ADDR_W-1:0] fifo_head,
  output logic              fifo_empty,
  input  logic              lost_clr,
  output logic [LOST_W-1:0] lost_count,
  output logic              overflow,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = PTR_W + 1;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  typedef enum logic [2:0] {S_IDLE, S_RD_REQ, S_RD_WAIT, S_WR_REQ, S_WR_WAIT} state_t;

  state_t            state_q;
  logic [ADDR_W-1:0] slot_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [DATA_W-1:0] bump_q;

  logic full_w, idle_w, push_w, drop_w, pop_w, start_w;

  assign full_w     = (cnt_q == FULL_CNT);
  assign fifo_empty = (cnt_q == '0);
  assign idle_w     = (state_q == S_IDLE);
  assign push_w     = in_valid & enable & ~full_w;
  assign drop_w     = in_valid & enable & full_w;
  assign start_w    = idle_w & enable & ~test_mode & ~fifo_empty;
  assign pop_w      = ((state_q == S_WR_WAIT) & mem_ack)
                    | (idle_w & test_mode & host_pop & ~fifo_empty);

  assign fifo_head  = slot_q[rd_ptr_q];
  assign mem_addr   = fifo_head;
  assign mem_wdata  = bump_q;
  assign mem_req    = (state_q == S_RD_REQ) | (state_q == S_WR_REQ);
  assign mem_we     = (state_q == S_WR_REQ);

  always_ff @(posedge clk) begin
    if (push_w) slot_q[wr_ptr_q] <= in_addr;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_w) wr_ptr_q <= (wr_ptr_q == LAST_PTR) ? '0 : wr_ptr_q + 1'b1;
      if (pop_w)  rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
      case ({push_w, pop_w})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      bump_q  <= '0;
    end else begin
      case (state_q)
        S_IDLE:    if (start_w) state_q <= S_RD_REQ;
        S_RD_REQ:  state_q <= S_RD_WAIT;
        S_RD_WAIT: if (mem_ack) begin
                     bump_q  <= mem_rdata + 1'b1;
                     state_q <= S_WR_REQ;
                   end
        S_WR_REQ:  state_q <= S_WR_WAIT;
        S_WR_WAIT: if (mem_ack) state_q <= S_IDLE;
        default:   state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lost_count <= '0;
      overflow   <= 1'b0;
    end else if (lost_clr) begin
      lost_count <= '0;
      overflow   <= 1'b0;
    end else if (drop_w) begin
      overflow <= 1'b1;
      if (~&lost_count) lost_count <= lost_count + 1'b1;
    end
  end
endmodule

// File: rtl/hist_incr_engine_chk.sv
module hist_incr_engine_chk #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int LOST_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              enable,
  input logic              test_mode,
  input logic              in_valid,
  input logic              lost_clr,
  input logic              full_w,
  input logic              idle_w,
  input logic              overflow,
  input logic [LOST_W-1:0] lost_count,
  input logic              mem_req,
  input logic              mem_we,
  input logic              mem_ack,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [DATA_W-1:0] mem_wdata,
  input logic [DATA_W-1:0] mem_rdata
);
  logic              wait_rd_q;
  logic [ADDR_W-1:0] rd_addr_q;
  logic [DATA_W-1:0] rd_data_q;
  logic [DATA_W-1:0] rd_next;

  assign rd_next = rd_data_q + 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wait_rd_q <= 1'b0;
      rd_addr_q <= '0;
      rd_data_q <= '0;
    end else if (mem_req && !mem_we) begin
      wait_rd_q <= 1'b1;
      rd_addr_q <= mem_addr;
    end else if (wait_rd_q && mem_ack) begin
      wait_rd_q <= 1'b0;
      rd_data_q <= mem_rdata;
    end
  end

  a_r2_req_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);
  a_r2_write_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_addr == rd_addr_q));
  a_r3_write_plus_one: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_we) |-> (mem_wdata == rd_next));
  a_r6_lost_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
    !lost_clr |=> (lost_count >= $past(lost_count)));
  a_r7_loss_flags: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && enable && full_w && !lost_clr) |=> overflow);
  a_r7_clear: assert property (@(posedge clk) disable iff (!rst_n)
    lost_clr |=> (lost_count == '0 && !overflow));
  a_r8_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_w && !enable) |=> !mem_req);
  a_r9_no_start_test: assert property (@(posedge clk) disable iff (!rst_n)
    (idle_w && test_mode) |=> !mem_req);
endmodule

bind hist_incr_engine hist_incr_engine_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LOST_W(LOST_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .test_mode(test_mode),
  .in_valid(in_valid), .lost_clr(lost_clr), .full_w(full_w), .idle_w(idle_w),
  .overflow(overflow), .lost_count(lost_count), .mem_req(mem_req),
  .mem_we(mem_we), .mem_ack(mem_ack), .mem_addr(mem_addr),
  .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
);

// File: tb/hist_incr_engine_bench.sv
module hist_incr_engine_bench;
  localparam int CLK_P  = 10;
  localparam int AW     = 32;
  localparam int DW     = 32;
  localparam int DEPTH  = 16;
  localparam int LW     = 4;

  typedef struct packed { logic [AW-1:0] a; logic [DW-1:0] d; } exp_t;

  logic clk = 1'b0, rst_n = 1'b0;
  logic enable = 1'b0, test_mode = 1'b0, in_valid = 1'b0, host_pop = 1'b0, lost_clr = 1'b0;
  logic [AW-1:0] in_addr = '0;
  logic [AW-1:0] fifo_head, mem_addr;
  logic fifo_empty, overflow, mem_req, mem_we;
  logic [LW-1:0] lost_count;
  logic [DW-1:0] mem_wdata;
  logic mem_ack = 1'b0;
  logic [DW-1:0] mem_rdata = '0;

  int tests = 0, fails = 0;
  bit done = 1'b0;
  exp_t exp_q[$];
  logic [AW-1:0] pop_q[$];
  logic [DW-1:0] mem_arr [logic [AW-1:0]];
  logic [DW-1:0] ref_arr [logic [AW-1:0]];

  hist_incr_engine #(.ADDR_W(AW), .DATA_W(DW), .DEPTH(DEPTH), .LOST_W(LW)) u_hist_incr_engine (
    .clk(clk), .rst_n(rst_n), .enable(enable), .test_mode(test_mode),
    .in_valid(in_valid), .in_addr(in_addr), .host_pop(host_pop),
    .fifo_head(fifo_head), .fifo_empty(fifo_empty), .lost_clr(lost_clr),
    .lost_count(lost_count), .overflow(overflow), .mem_req(mem_req),
    .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata));

  always #(CLK_P/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] mem_rd(input logic [AW-1:0] a);
    return mem_arr.exists(a) ? mem_arr[a] : '0;
  endfunction

  function automatic logic [DW-1:0] ref_rd(input logic [AW-1:0] a);
    return ref_arr.exists(a) ? ref_arr[a] : '0;
  endfunction

  // memory responder: one outstanding request, latency 1..4 cycles
  bit pend = 1'b0, pend_we = 1'b0;
  logic [AW-1:0] pend_addr = '0;
  logic [DW-1:0] pend_data = '0;
  int wait_n = 0, lat_seq = 0;
  always @(negedge clk) begin
    mem_ack = 1'b0;
    if (pend) begin
      if (wait_n == 0) begin
        mem_ack = 1'b1;
        if (pend_we) mem_arr[pend_addr] = pend_data;
        else mem_rdata = mem_rd(pend_addr);
        pend = 1'b0;
      end else wait_n--;
    end else if (rst_n && mem_req) begin
      pend = 1'b1; pend_we = mem_we; pend_addr = mem_addr; pend_data = mem_wdata;
      wait_n = lat_seq % 4; lat_seq++;
    end
  end

  // scoreboard monitor
  always @(negedge clk) begin
    if (rst_n && mem_req) begin
      if (exp_q.size() == 0) begin
        check(1'b0, "R1 unexpected request", {32'h0, mem_addr}, 64'h0);
      end else if (!mem_we) begin
        check(mem_addr == exp_q[0].a, "R2 read address", {32'h0, mem_addr}, {32'h0, exp_q[0].a});
      end else begin
        check(mem_addr == exp_q[0].a, "R2 write address", {32'h0, mem_addr}, {32'h0, exp_q[0].a});
        check(mem_wdata == exp_q[0].d, "R4 write data", {32'h0, mem_wdata}, {32'h0, exp_q[0].d});
        void'(exp_q.pop_front());
      end
    end
  end

  // kind: 0 engine consumes, 1 held for host pop, 2 dropped or ignored
  task automatic push(input logic [AW-1:0] a, input int kind);
    in_valid = 1'b1; in_addr = a;
    if (kind == 0) begin
      exp_t e;
      e.a = a; e.d = ref_rd(a) + 1'b1;
      ref_arr[a] = e.d;
      exp_q.push_back(e);
    end else if (kind == 1) pop_q.push_back(a);
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  task automatic drain();
    for (int i = 0; i < 2000 && (exp_q.size() != 0 || !fifo_empty); i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(mem_req == 1'b0, "R10 mem_req", {63'h0, mem_req}, 64'h0);
    check(lost_count == '0, "R10 lost_count", {60'h0, lost_count}, 64'h0);
    check(overflow == 1'b0, "R10 overflow", {63'h0, overflow}, 64'h0);
    check(fifo_empty == 1'b1, "R10 fifo_empty", {63'h0, fifo_empty}, 64'h1);

    // R1/R2: spaced addresses
    enable = 1'b1;
    mem_arr[32'h40] = 32'd7; ref_arr[32'h40] = 32'd7;
    push(32'h40, 0); repeat (9) @(negedge clk);
    push(32'h1234, 0); repeat (9) @(negedge clk);
    push(32'h40, 0);
    drain();
    check(exp_q.size() == 0, "R2 all spaced increments written", exp_q.size(), 0);
    check(mem_rd(32'h40) == 32'd9, "R2 bin value", mem_rd(32'h40), 9);

    // R4: back-to-back burst with repeats
    for (int i = 0; i < 12; i++) push(32'h200 + (i % 3) * 4, 0);
    drain();
    for (int k = 0; k < 3; k++)
      check(mem_rd(32'h200 + k * 4) == 32'd4, "R4 repeated bins accumulate",
            mem_rd(32'h200 + k * 4), 4);

    // R3: wrap
    mem_arr[32'h100] = 32'hFFFF_FFFF; ref_arr[32'h100] = 32'hFFFF_FFFF;
    push(32'h100, 0);
    drain();
    check(mem_rd(32'h100) == 32'h0, "R3 wrap to zero", mem_rd(32'h100), 0);

    // R8: disable during an increment
    push(32'h300, 0);
    push(32'h304, 0);
    while (!mem_req) @(negedge clk);
    enable = 1'b0;
    repeat (30) @(negedge clk);
    check(exp_q.size() == 1, "R8 running increment completes, next held", exp_q.size(), 1);
    check(fifo_empty == 1'b0, "R8 entry stays buffered", {63'h0, fifo_empty}, 64'h0);
    push(32'h308, 2);
    @(negedge clk);
    check(lost_count == '0, "R8 disabled input not counted", {60'h0, lost_count}, 64'h0);
    enable = 1'b1;
    drain();
    check(exp_q.size() == 0 && fifo_empty, "R8 resumes, ignored address absent", exp_q.size(), 0);

    // R5/R6/R7/R9: fill in test mode
    test_mode = 1'b1;
    for (int i = 0; i < DEPTH; i++) push(32'h1000 + i * 4, 1);
    for (int i = 0; i < 5; i++) push(32'h2000 + i, 2);
    check(lost_count == 4'd5, "R5 losses counted", {60'h0, lost_count}, 5);
    check(overflow == 1'b1, "R7 overflow set", {63'h0, overflow}, 1);
    for (int i = 0; i < 15; i++) push(32'h3000 + i, 2);
    check(lost_count == 4'hF, "R6 saturation", {60'h0, lost_count}, 15);
    repeat (10) @(negedge clk);
    check(exp_q.size() == 0, "R9 no engine activity in test mode", exp_q.size(), 0);
    while (pop_q.size() != 0) begin
      check(fifo_head == pop_q[0], "R9 head order", {32'h0, fifo_head}, {32'h0, pop_q[0]});
      void'(pop_q.pop_front());
      host_pop = 1'b1;
      @(negedge clk);
      host_pop = 1'b0;
    end
    check(fifo_empty == 1'b1, "R9 empty after host pops", {63'h0, fifo_empty}, 1);
    check(overflow == 1'b1, "R7 overflow sticky", {63'h0, overflow}, 1);
    lost_clr = 1'b1;
    @(negedge clk);
    lost_clr = 1'b0;
    check(lost_count == '0, "R7 clear count", {60'h0, lost_count}, 0);
    check(overflow == 1'b0, "R7 clear flag", {63'h0, overflow}, 0);

    // R1: normal operation again
    test_mode = 1'b0;
    push(32'h500, 0);
    push(32'h504, 0);
    drain();
    check(exp_q.size() == 0 && mem_rd(32'h504) == 32'd1, "R1 accepts after test mode",
          mem_rd(32'h504), 1);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule